// File: doc/BRIEF.md
# SPI Byte Memory Command Controller

This block is the serial front end of a small byte-wide nonvolatile store. A host drives it as an SPI slave in mode 0: chip select active low, clock idle low, input bits taken on rising clock edges and output bits launched on falling ones, always most significant bit first. Each frame opens with an 8-bit instruction. Depending on the instruction, an address byte and data bytes may follow. The controller decodes the frame, drives the serial output only while it returns data, and keeps a 256-byte register-file array.

All pins are brought into the system clock domain through synchronizer chains, so the serial clock must be several times slower than the system clock. Writes go through a write-enable latch that software sets and clears. A write to the array or to the status register starts only when chip select rises on a byte boundary. A counter then models the internal programming time. During that time a busy flag reads 1, and only the status-read instruction is accepted. When the write completes, the latch clears itself. A power-up reset input clears the latch and drops any write in progress, but keeps the stored contents.

Top module: `spimem_ctrl`

## Requirements
- R1: Instruction, address and data bits travel MSB first. SI is taken on rising SCK edges from the first rising edge after CS_n falls, and SO changes only after falling SCK edges.
- R2: Instruction 0x06 sets the write-enable latch, and instruction 0x04 clears it. The latch reads in status bit 1.
- R3: Instruction 0x05 returns the status byte {stored bits 7:2, latch in bit 1, busy in bit 0} and repeats it for every further byte of the frame. After rst it reads 0x00.
- R4: Instruction 0x02, then an address byte, then a data byte, stores the first data byte at that address once CS_n rises on a byte boundary and the write time has passed. Further data bytes in the same frame are discarded.
- R5: Instructions 0x02 and 0x01 have no effect while the write-enable latch is clear.
- R6: A started write holds the busy bit at 1 for WR_CYCLES system clocks. The write-enable latch clears when the write completes.
- R7: While busy, instruction 0x05 is still served. Every other instruction is ignored, and this includes reads, which leave SO_OE low.
- R8: If CS_n rises with a partial byte shifted in, or before any data byte arrives, no write starts and the write-enable latch keeps its value.
- R9: Instruction 0x03, then an address byte, streams bytes from that address upward, wrapping from 0xFF to 0x00.
- R10: Instruction 0x01 with a data byte writes data bits 7:2 into status bits 7:2 after the write time. Data bits 1:0 are ignored.
- R11: so_oe is high only while read data or status is being shifted out with CS_n low, and it is low whenever CS_n is high.
- R12: A por pulse clears the write-enable latch and abandons a running write, but keeps the array and status bits 7:2. rst clears the array as well.
- R13: SCK may pause for any time in the middle of a byte, and the frame resumes at the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, clears everything including the array |
| por | input | 1 | Power-up reset pulse, clears the latch and the busy state only |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, valid while so_oe is high |
| so_oe | output | 1 | Output enable for so, models the high-impedance state when low |

## Verification
Every pin passes two synchronizer flops and one edge-detect register, so an SCK edge acts on the third system clock after the pin moves. A new SO bit therefore settles within four clocks of a falling SCK edge. The bench holds each SCK level for five clocks and samples SO just before it raises SCK, away from that window. A write starts about three clocks after CS_n rises and stays busy for WR_CYCLES clocks. The bench sets the write time long enough that two status reads fall inside it, and it waits WR_CYCLES plus 20 clocks before it reads back the result. An address sweep and one full streaming read compare every array location against a model the bench computes itself.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

    localparam int BYTE_W = 8;
    localparam int NV_W   = 6;

    typedef enum logic [7:0] {
        OP_WRSR  = 8'h01,
        OP_WRITE = 8'h02,
        OP_READ  = 8'h03,
        OP_WRDI  = 8'h04,
        OP_RDSR  = 8'h05,
        OP_WREN  = 8'h06
    } opcode_e;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_WDATA,
        PH_SDATA,
        PH_RDATA,
        PH_RSTAT,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_ARRAY,
        WK_STATUS
    } wkind_e;

    typedef struct packed {
        wkind_e             kind;
        logic [BYTE_W-1:0]  addr;
        logic [BYTE_W-1:0]  data;
    } wjob_t;

    function automatic logic [BYTE_W-1:0] status_byte(
        input logic [NV_W-1:0] nv,
        input logic            wel,
        input logic            wip
    );
        return {nv, wel, wip};
    endfunction

    function automatic logic takes_data(input phase_e ph);
        return (ph == PH_WDATA) || (ph == PH_SDATA);
    endfunction

endpackage

// File: rtl/spimem_pin_sync.sv
module spimem_pin_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o
);
    // One flop chain per pin; STAGES must be at least 2.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[b]}};
            else     chain <= {chain[STAGES-2:0], pin_i[b]};
        end
        assign lvl_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/spimem_rx.sv
module spimem_rx #(
    parameter int BW = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  sample,
    input  logic                  bit_in,
    output logic [BW-1:0]         byte_o,
    output logic                  byte_stb,
    output logic [$clog2(BW)-1:0] bit_pos
);
    localparam int PW = $clog2(BW);
    localparam logic [PW-1:0] LAST = PW'(BW - 1);

    logic [BW-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh       <= '0;
            bit_pos  <= '0;
            byte_stb <= 1'b0;
            byte_o   <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (sample) begin
                sh <= {sh[BW-2:0], bit_in};
                if (bit_pos == LAST) begin
                    bit_pos  <= '0;
                    byte_stb <= 1'b1;
                    byte_o   <= {sh[BW-2:0], bit_in};
                end else begin
                    bit_pos <= bit_pos + PW'(1);
                end
            end
        end
    end

    // R1
    stb_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> (bit_pos == '0));
endmodule

// File: rtl/spimem_wtimer.sv
module spimem_wtimer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic abort,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = busy && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !done && !abort |=> busy);
    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    // R6
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cnt == '0));
endmodule

// File: rtl/spimem_tx.sv
module spimem_tx #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [BW-1:0] load_val,
    input  logic          shift,
    output logic          so,
    output logic          so_oe
);
    logic [BW-1:0] sh;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh    <= '0;
            armed <= 1'b0;
            so    <= 1'b1;
            so_oe <= 1'b0;
        end else if (load) begin
            sh    <= load_val;
            armed <= 1'b1;
        end else if (shift && armed) begin
            so    <= sh[BW-1];
            sh    <= {sh[BW-2:0], 1'b0};
            so_oe <= 1'b1;
        end
    end

    // R11
    oe_armed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(so_oe) |-> $past(armed));
endmodule

// File: rtl/spimem_ctrl.sv
module spimem_ctrl
    import spimem_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int WR_CYCLES   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so,
    output logic so_oe
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int BW    = BYTE_W;
    localparam int PW    = $clog2(BW);

    // ---------------- pin capture ----------------
    logic [2:0] lvl;
    logic       cs_q, sck_q;

    spimem_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin_i({si, sck, cs_n}),
        .lvl_o(lvl)
    );

    logic cs_idle, si_lvl, sck_rise, sck_fall, cs_end, frame_clr;
    assign cs_idle   = lvl[0];
    assign si_lvl    = lvl[2];
    assign sck_rise  = lvl[1] & ~sck_q;
    assign sck_fall  = ~lvl[1] & sck_q;
    assign cs_end    = lvl[0] & ~cs_q;
    assign frame_clr = cs_idle | por;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= lvl[0];
            sck_q <= lvl[1];
        end
    end

    // ---------------- byte receiver ----------------
    logic [BW-1:0] rx_byte;
    logic          rx_stb;
    logic [PW-1:0] rx_pos;

    spimem_rx #(.BW(BW)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .clr     (frame_clr),
        .sample  (sck_rise),
        .bit_in  (si_lvl),
        .byte_o  (rx_byte),
        .byte_stb(rx_stb),
        .bit_pos (rx_pos)
    );

    // ---------------- state ----------------
    phase_e            phase;
    logic [BW-1:0]     cmd_q;
    wjob_t             job;
    logic              have_data;
    logic              wel;
    logic [NV_W-1:0]   nv;
    logic [ADDR_W-1:0] rd_ptr;
    logic              tx_load;
    logic [BW-1:0]     tx_val;
    logic [BW-1:0]     mem [DEPTH];
    logic              busy, done, launch;

    // A write starts only at a byte boundary with a data byte captured.
    assign launch = cs_end && takes_data(phase) && have_data
                    && (rx_pos == '0) && !por;

    spimem_wtimer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .abort(por),
        .start(launch),
        .busy (busy),
        .done (done)
    );

    spimem_tx #(.BW(BW)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .clr     (frame_clr),
        .load    (tx_load),
        .load_val(tx_val),
        .shift   (sck_fall),
        .so      (so),
        .so_oe   (so_oe)
    );

    // ---------------- array ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (done && job.kind == WK_ARRAY) begin
            mem[job.addr[ADDR_W-1:0]] <= job.data;
        end
    end

    // ---------------- command sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_CMD;
            cmd_q     <= '0;
            job       <= '{kind: WK_NONE, addr: '0, data: '0};
            have_data <= 1'b0;
            wel       <= 1'b0;
            nv        <= '0;
            rd_ptr    <= '0;
            tx_load   <= 1'b0;
            tx_val    <= '0;
        end else begin
            tx_load <= 1'b0;
            if (done) begin
                wel <= 1'b0;
                if (job.kind == WK_STATUS) nv <= job.data[BW-1:BW-NV_W];
            end
            if (por) begin
                wel       <= 1'b0;
                phase     <= PH_CMD;
                have_data <= 1'b0;
            end else if (frame_clr) begin
                phase     <= PH_CMD;
                have_data <= 1'b0;
            end else if (rx_stb) begin
                case (phase)
                    PH_CMD: begin
                        cmd_q <= rx_byte;
                        if (busy && rx_byte != OP_RDSR) begin
                            phase <= PH_SKIP;
                        end else begin
                            case (rx_byte)
                                OP_WREN: begin
                                    wel   <= 1'b1;
                                    phase <= PH_SKIP;
                                end
                                OP_WRDI: begin
                                    wel   <= 1'b0;
                                    phase <= PH_SKIP;
                                end
                                OP_RDSR: begin
                                    tx_load <= 1'b1;
                                    tx_val  <= status_byte(nv, wel, busy);
                                    phase   <= PH_RSTAT;
                                end
                                OP_WRSR: begin
                                    if (wel) begin
                                        job.kind <= WK_STATUS;
                                        phase    <= PH_SDATA;
                                    end else begin
                                        phase <= PH_SKIP;
                                    end
                                end
                                OP_WRITE: begin
                                    if (wel) begin
                                        job.kind <= WK_ARRAY;
                                        phase    <= PH_ADDR;
                                    end else begin
                                        phase <= PH_SKIP;
                                    end
                                end
                                OP_READ: phase <= PH_ADDR;
                                default: phase <= PH_SKIP;
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        if (cmd_q == OP_READ) begin
                            tx_load <= 1'b1;
                            tx_val  <= mem[rx_byte[ADDR_W-1:0]];
                            rd_ptr  <= rx_byte[ADDR_W-1:0] + ADDR_W'(1);
                            phase   <= PH_RDATA;
                        end else begin
                            job.addr <= rx_byte;
                            phase    <= PH_WDATA;
                        end
                    end
                    PH_WDATA, PH_SDATA: begin
                        if (!have_data) begin
                            job.data  <= rx_byte;
                            have_data <= 1'b1;
                        end
                    end
                    PH_RDATA: begin
                        tx_load <= 1'b1;
                        tx_val  <= mem[rd_ptr];
                        rd_ptr  <= rd_ptr + ADDR_W'(1);
                    end
                    PH_RSTAT: begin
                        tx_load <= 1'b1;
                        tx_val  <= status_byte(nv, wel, busy);
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- assertions ----------------
    // R5
    launch_wel_chk: assert property (@(posedge clk) disable iff (rst)
        launch |-> wel);
    // R7
    launch_idle_chk: assert property (@(posedge clk) disable iff (rst)
        launch |-> !busy);
    // R6
    wel_clear_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !wel);
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !done && !por |=> $stable(wel) && $stable(nv));
    // R11
    oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_idle |=> !so_oe);
    // R12
    por_clear_chk: assert property (@(posedge clk) disable iff (rst)
        por |=> !wel && !busy);
endmodule

// File: tb/spimem_ctrl_tb.sv
module spimem_ctrl_tb;
    localparam int HP    = 5;
    localparam int WRC   = 600;
    localparam int WAITW = WRC + 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic so, so_oe;

    spimem_ctrl #(.ADDR_W(8), .WR_CYCLES(WRC), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .por(por), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe)
    );

    always #10 clk = ~clk;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;
    logic [7:0] model [256];
    logic [7:0] rb, st;
    bit   oe_all, oe_any;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Send the top nb bits of tx; optional pause after bit index pause_at.
    task automatic xbits(input logic [7:0] tx, input int nb, input int pause_at,
                         output logic [7:0] rx);
        rx = '0; oe_all = 1; oe_any = 0;
        for (int i = 7; i >= 8 - nb; i--) begin
            si = tx[i];
            tick(HP);
            rx[i] = so;
            oe_all = oe_all & so_oe;
            oe_any = oe_any | so_oe;
            sck = 1'b1;
            tick(HP);
            sck = 1'b0;
            if (i == pause_at) tick(60);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, -1, rx);
    endtask

    task automatic begin_f();
        cs_n = 1'b0;
        tick(HP);
    endtask

    task automatic end_f();
        tick(HP);
        cs_n = 1'b1;
        tick(HP + 3);
    endtask

    task automatic op1(input logic [7:0] op);
        begin_f(); xbyte(op, rb); end_f();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        begin_f(); xbyte(8'h05, d); xbyte(8'h00, s); end_f();
    endtask

    task automatic write_b(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] r;
        begin_f(); xbyte(8'h02, r); xbyte(a, r); xbyte(d, r); end_f();
    endtask

    task automatic read_b(input logic [7:0] a, output logic [7:0] d,
                          output bit hdr_oe, output bit dat_oe);
        logic [7:0] r;
        begin_f();
        xbyte(8'h03, r); hdr_oe = oe_any;
        xbyte(a, r);     hdr_oe = hdr_oe | oe_any;
        xbyte(8'h00, d); dat_oe = oe_all;
        end_f();
    endtask

    task automatic wr_full(input logic [7:0] a, input logic [7:0] d);
        op1(8'h06);
        write_b(a, d);
        model[a] = d;
        tick(WAITW);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        bit h_oe, d_oe;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(5);

        // R11 / R3: reset state
        check(so_oe == 1'b0, "R11 idle oe", so_oe, 0);
        rdsr(st);
        check(st == 8'h00, "R3 status after reset", st, 8'h00);

        // R2: latch set and clear
        op1(8'h06); rdsr(st);
        check(st == 8'h02, "R2 set latch", st, 8'h02);
        op1(8'h04); rdsr(st);
        check(st == 8'h00, "R2 clear latch", st, 8'h00);

        // R5: gated writes
        write_b(8'h10, 8'h5A); tick(WAITW);
        read_b(8'h10, rb, h_oe, d_oe);
        check(rb == model[8'h10], "R5 write without latch", rb, model[8'h10]);
        begin_f(); xbyte(8'h01, rb); xbyte(8'hFF, rb); end_f(); tick(WAITW);
        rdsr(st);
        check(st == 8'h00, "R5 status write without latch", st, 8'h00);

        // R6 / R7: busy window
        op1(8'h06);
        write_b(8'h20, 8'hC3);
        rdsr(st);
        check(st == 8'h03, "R6 busy and latch during write", st, 8'h03);
        op1(8'h04);
        rdsr(st);
        check(st == 8'h03, "R7 clear ignored while busy", st, 8'h03);
        read_b(8'h20, rb, h_oe, d_oe);
        check(!h_oe && !d_oe, "R7 read ignored while busy", d_oe, 0);
        tick(WAITW);
        model[8'h20] = 8'hC3;
        rdsr(st);
        check(st == 8'h00, "R6 latch cleared after write", st, 8'h00);
        read_b(8'h20, rb, h_oe, d_oe);
        check(rb == 8'hC3, "R4 stored byte", rb, 8'hC3);
        check(!h_oe && d_oe, "R11 oe only in data phase", {h_oe, d_oe}, 1);
        check(so_oe == 1'b0, "R11 oe low after frame", so_oe, 0);

        // R8: aborted frames
        op1(8'h06);
        begin_f(); xbyte(8'h02, rb); xbyte(8'h30, rb); xbits(8'hFF, 5, -1, rb); end_f();
        rdsr(st);
        check(st == 8'h02, "R8 partial byte aborts", st, 8'h02);
        begin_f(); xbyte(8'h02, rb); xbyte(8'h31, rb); end_f();
        rdsr(st);
        check(st == 8'h02, "R8 no data byte aborts", st, 8'h02);
        tick(WAITW);
        read_b(8'h30, rb, h_oe, d_oe);
        check(rb == model[8'h30], "R8 array untouched", rb, model[8'h30]);
        op1(8'h04);

        // R4: extra data bytes discarded
        op1(8'h06);
        begin_f(); xbyte(8'h02, rb); xbyte(8'h40, rb); xbyte(8'hA5, rb); xbyte(8'h3C, rb); end_f();
        model[8'h40] = 8'hA5;
        tick(WAITW);
        read_b(8'h40, rb, h_oe, d_oe);
        check(rb == 8'hA5, "R4 first data byte", rb, 8'hA5);
        read_b(8'h41, rb, h_oe, d_oe);
        check(rb == model[8'h41], "R4 no spill", rb, model[8'h41]);

        // R10 / R3: status write and repeated status bytes
        op1(8'h06);
        begin_f(); xbyte(8'h01, rb); xbyte(8'hFF, rb); end_f();
        tick(WAITW);
        begin_f(); xbyte(8'h05, rb); xbyte(8'h00, st); xbyte(8'h00, rb); end_f();
        check(st == 8'hFC, "R10 status bits written", st, 8'hFC);
        check(rb == 8'hFC, "R3 status repeats", rb, 8'hFC);

        // R13: paused clock
        op1(8'h06);
        begin_f(); xbyte(8'h02, rb); xbits(8'h50, 8, 4, rb); xbits(8'h96, 8, 2, rb); end_f();
        model[8'h50] = 8'h96;
        tick(WAITW);
        read_b(8'h50, rb, h_oe, d_oe);
        check(rb == 8'h96, "R13 pause keeps bit position", rb, 8'h96);

        // R9: wrap
        wr_full(8'hFF, 8'h77);
        begin_f(); xbyte(8'h03, rb); xbyte(8'hFE, rb);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] ea;
            ea = 8'hFE + 8'(k);
            xbyte(8'h00, rb);
            check(rb == model[ea], "R9 streaming wrap", rb, model[ea]);
        end
        end_f();

        // R12: power-up reset keeps contents
        op1(8'h06);
        begin_f(); xbyte(8'h01, rb); xbyte(8'hA8, rb); end_f();
        tick(WAITW);
        op1(8'h06);
        write_b(8'h60, 8'hEE);
        tick(20);
        por = 1'b1; tick(2); por = 1'b0; tick(5);
        rdsr(st);
        check(st == 8'hA8, "R12 por clears latch and busy", st, 8'hA8);
        tick(WAITW);
        read_b(8'h60, rb, h_oe, d_oe);
        check(rb == model[8'h60], "R12 write abandoned", rb, model[8'h60]);
        read_b(8'h20, rb, h_oe, d_oe);
        check(rb == 8'hC3, "R12 array kept", rb, 8'hC3);

        // R1 / R4 / R9: address sweep and full streaming read
        for (int a = 0; a < 256; a += 4) wr_full(8'(a), 8'((a * 29 + 7) & 8'hFF));
        begin_f(); xbyte(8'h03, rb); xbyte(8'h00, rb);
        for (int i = 0; i < 256; i++) begin
            xbyte(8'h00, rb);
            check(rb == model[i], "R1 R9 sweep readback", rb, model[i]);
        end
        end_f();

        // R12: full reset clears the array
        rst = 1'b1; tick(3); rst = 1'b0; tick(5);
        rdsr(st);
        check(st == 8'h00, "R12 rst clears status", st, 8'h00);
        read_b(8'h20, rb, h_oe, d_oe);
        check(rb == 8'h00, "R12 rst clears array", rb, 8'h00);

        finished = 1;
        summary();
        $finish;
    end
endmodule